// File: doc/BRIEF.md
# USB Link Power Management Handshake and Suspend Control

This block sits behind the token decoder of a USB device controller. It answers each extended Link Power Management token and tracks the link's LPM sleep state. For every token it returns a handshake code: ACK, NYET, or nothing. When software still has data queued, it gets NYET. With the queue empty it gets ACK. If the feature is switched off, no handshake is returned and the host times out. The block also keeps the host's requested resume duration and a flag that records whether the host allowed remote wake.

After an ACK, the block counts a retry window of `WINDOW_MS` millisecond ticks and then enters LPM sleep. A later token during the window restarts or cancels the count, depending on that token's outcome. Three events end the sleep: a host-driven resume, a bus reset, or a software write of 0 to the sleep flag. The software write is accepted only when the host granted remote wake, and it also raises a one-cycle remote-wakeup request.

Top module: `usb_lpm_link_ctrl`

## Requirements
- R1: If `tok_vld` is high while `lpm_sup` is 1 and `data_pend` is 0, `hs_code` equals 2'b01 (ACK) for the single following cycle.
- R2: If `tok_vld` is high while `lpm_sup` is 1 and `data_pend` is 1, `hs_code` equals 2'b10 (NYET) for the single following cycle.
- R3: `hs_code` is 2'b00 (no handshake) in every cycle that does not follow an accepted token, including the cycle after a token received while `lpm_sup` is 0.
- R4: On `tok_vld`, `tok_hird` is stored and appears on `hird_hw` from the next cycle until the next token.
- R5: The `tok_rwake` bit of a token received while `lpm_sup` is 1 sets `rwake_en`. Three events clear it: `host_resume`, `bus_reset`, or an accepted software wake.
- R6: After an ACK, `lpm_susp` rises at the clock edge that samples the `WINDOW_MS`-th `tick_1ms` pulse after the token cycle. A tick in the token cycle itself is not counted.
- R7: A token that arrives during an open window restarts the count if it is answered ACK. If it is answered NYET, or not answered at all, it closes the window.
- R8: `host_resume` while `lpm_sup` is 1 clears `lpm_susp` and closes any open window.
- R9: A `susp_wr` with `susp_wdata` 0 is accepted only while `lpm_susp`, `rwake_en` and `lpm_sup` are all 1. An accepted write clears `lpm_susp` and `rwake_en` and pulses `rwake_req` for exactly one cycle. Any other `susp_wr` has no effect.
- R10: While `lpm_sup` is 0, `lpm_susp` holds its value. A bus reset is the only exception.
- R11: `bus_reset` clears `lpm_susp` and `rwake_en` and closes any open window.
- R12: `cfg_wr` loads `cfg_sup`, `cfg_pend` and `cfg_hird_sw` into `lpm_sup`, `data_pend` and `hird_sw` on the next cycle. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_vld | input | 1 | One-cycle strobe: LPM token received |
| tok_hird | input | HIRD_W | Resume duration carried by the token |
| tok_rwake | input | 1 | Remote-wake permission bit carried by the token |
| host_resume | input | 1 | Host-initiated resume detected |
| bus_reset | input | 1 | USB bus reset detected |
| tick_1ms | input | 1 | One-cycle millisecond tick |
| cfg_wr | input | 1 | Software write strobe for the configuration fields |
| cfg_sup | input | 1 | Write data: LPM supported |
| cfg_pend | input | 1 | Write data: data pending |
| cfg_hird_sw | input | HIRD_W | Write data: software resume duration |
| susp_wr | input | 1 | Software write strobe for the LPM sleep flag |
| susp_wdata | input | 1 | Write data for the LPM sleep flag |
| hs_code | output | 2 | Handshake code: 00 none, 01 ACK, 10 NYET |
| hird_hw | output | HIRD_W | Resume duration of the last token |
| hird_sw | output | HIRD_W | Software resume duration |
| lpm_sup | output | 1 | LPM supported |
| data_pend | output | 1 | Data pending |
| rwake_en | output | 1 | Host granted remote wake |
| lpm_susp | output | 1 | LPM sleep state |
| rwake_req | output | 1 | One-cycle remote-wakeup request |

## Verification
On every cycle, the assertions check the handshake code against the configuration sampled with each token, and they check that `hird_hw` captures the token's value. They also check that resume and bus reset clear state and that the sleep flag is frozen while the feature is off. Finally, they check that any remote-wakeup request follows a granted sleep and lasts a single cycle. The exact window length cannot be seen from single-cycle relations: the window must be counted across many ticks, restarted by a second ACK and cancelled by a NYET. Only the bench scenarios show those, together with the random sequences compared against a bench model.

// File: rtl/usb_lpm_pkg.sv
package usb_lpm_pkg;
   typedef enum logic [1:0] {
      HS_NONE = 2'b00,
      HS_ACK  = 2'b01,
      HS_NYET = 2'b10
   } lpm_hs_e;
endpackage

// File: rtl/usb_lpm_cfg_regs.sv
module usb_lpm_cfg_regs #(
   parameter int HIRD_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_sup,
   input  logic              cfg_pend,
   input  logic [HIRD_W-1:0] cfg_hird_sw,
   output logic              sup_q,
   output logic              pend_q,
   output logic [HIRD_W-1:0] hird_sw_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sup_q     <= 1'b0;
         pend_q    <= 1'b0;
         hird_sw_q <= '0;
      end else if (cfg_wr) begin
         sup_q     <= cfg_sup;
         pend_q    <= cfg_pend;
         hird_sw_q <= cfg_hird_sw;
      end
   end
endmodule

// File: rtl/usb_lpm_hs_decide.sv
module usb_lpm_hs_decide
   import usb_lpm_pkg::*;
#(
   parameter int HIRD_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_vld,
   input  logic [HIRD_W-1:0] tok_hird,
   input  logic              sup,
   input  logic              pend,
   output logic              ack_now,
   output logic              tok_other,
   output lpm_hs_e           hs_q,
   output logic [HIRD_W-1:0] hird_hw_q
);
   lpm_hs_e hs_d;

   always_comb begin
      hs_d = HS_NONE;
      if (tok_vld && sup) hs_d = pend ? HS_NYET : HS_ACK;
   end

   assign ack_now   = (hs_d == HS_ACK);
   assign tok_other = tok_vld && (hs_d != HS_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q      <= HS_NONE;
         hird_hw_q <= '0;
      end else begin
         hs_q <= hs_d;
         if (tok_vld) hird_hw_q <= tok_hird;
      end
   end
endmodule

// File: rtl/usb_lpm_retry_timer.sv
module usb_lpm_retry_timer #(
   parameter int WINDOW_MS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic abort,
   input  logic start,
   input  logic stop,
   input  logic tick,
   output logic expire,
   output logic armed
);
   localparam int CNT_W = (WINDOW_MS > 1) ? $clog2(WINDOW_MS + 1) : 1;

   logic quiet;
   assign quiet = !abort && !start && !stop;

   if (WINDOW_MS < 1) begin : g_bad_window
      $error("usb_lpm_retry_timer: WINDOW_MS must be at least 1");
   end

   if (WINDOW_MS == 1) begin : g_single
      logic armed_q;
      assign expire = quiet && tick && armed_q;
      assign armed  = armed_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  armed_q <= 1'b0;
         else if (abort)              armed_q <= 1'b0;
         else if (start)              armed_q <= 1'b1;
         else if (stop || expire)     armed_q <= 1'b0;
      end
   end else begin : g_count
      localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WINDOW_MS);
      logic             armed_q;
      logic [CNT_W-1:0] cnt_q;
      assign expire = quiet && tick && armed_q && (cnt_q == CNT_W'(1));
      assign armed  = armed_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
         end else if (abort) begin
            armed_q <= 1'b0;
         end else if (start) begin
            armed_q <= 1'b1;
            cnt_q   <= RELOAD;
         end else if (stop) begin
            armed_q <= 1'b0;
         end else if (tick && armed_q) begin
            if (cnt_q == CNT_W'(1)) armed_q <= 1'b0;
            else                    cnt_q   <= cnt_q - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/usb_lpm_susp_ctrl.sv
module usb_lpm_susp_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic sup,
   input  logic bus_reset,
   input  logic host_resume,
   input  logic expire,
   input  logic tok_vld,
   input  logic tok_rwake,
   input  logic susp_wr,
   input  logic susp_wdata,
   output logic susp_q,
   output logic rwake_en_q,
   output logic rwake_req_q
);
   logic sw_wake;
   assign sw_wake = susp_wr && !susp_wdata && susp_q && rwake_en_q && sup;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         susp_q      <= 1'b0;
         rwake_en_q  <= 1'b0;
         rwake_req_q <= 1'b0;
      end else begin
         rwake_req_q <= sw_wake;

         if (bus_reset)                       susp_q <= 1'b0;
         else if (sup) begin
            if (host_resume || sw_wake)       susp_q <= 1'b0;
            else if (expire)                  susp_q <= 1'b1;
         end

         if (bus_reset || host_resume || sw_wake) rwake_en_q <= 1'b0;
         else if (tok_vld && sup && tok_rwake)    rwake_en_q <= 1'b1;
      end
   end
endmodule

// File: rtl/usb_lpm_link_ctrl.sv
module usb_lpm_link_ctrl
   import usb_lpm_pkg::*;
#(
   parameter int HIRD_W    = 4,
   parameter int WINDOW_MS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_vld,
   input  logic [HIRD_W-1:0] tok_hird,
   input  logic              tok_rwake,
   input  logic              host_resume,
   input  logic              bus_reset,
   input  logic              tick_1ms,
   input  logic              cfg_wr,
   input  logic              cfg_sup,
   input  logic              cfg_pend,
   input  logic [HIRD_W-1:0] cfg_hird_sw,
   input  logic              susp_wr,
   input  logic              susp_wdata,
   output logic [1:0]        hs_code,
   output logic [HIRD_W-1:0] hird_hw,
   output logic [HIRD_W-1:0] hird_sw,
   output logic              lpm_sup,
   output logic              data_pend,
   output logic              rwake_en,
   output logic              lpm_susp,
   output logic              rwake_req
);
   if (HIRD_W < 1) begin : g_bad_hird
      $error("usb_lpm_link_ctrl: HIRD_W must be at least 1");
   end

   logic    ack_now;
   logic    tok_other;
   logic    expire;
   logic    armed;
   lpm_hs_e hs_q;

   usb_lpm_cfg_regs #(.HIRD_W(HIRD_W)) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr      (cfg_wr),
      .cfg_sup     (cfg_sup),
      .cfg_pend    (cfg_pend),
      .cfg_hird_sw (cfg_hird_sw),
      .sup_q       (lpm_sup),
      .pend_q      (data_pend),
      .hird_sw_q   (hird_sw)
   );

   usb_lpm_hs_decide #(.HIRD_W(HIRD_W)) u_hs (
      .clk       (clk),
      .rst_n     (rst_n),
      .tok_vld   (tok_vld),
      .tok_hird  (tok_hird),
      .sup       (lpm_sup),
      .pend      (data_pend),
      .ack_now   (ack_now),
      .tok_other (tok_other),
      .hs_q      (hs_q),
      .hird_hw_q (hird_hw)
   );

   usb_lpm_retry_timer #(.WINDOW_MS(WINDOW_MS)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .abort  (bus_reset || host_resume),
      .start  (ack_now),
      .stop   (tok_other),
      .tick   (tick_1ms),
      .expire (expire),
      .armed  (armed)
   );

   usb_lpm_susp_ctrl u_susp (
      .clk         (clk),
      .rst_n       (rst_n),
      .sup         (lpm_sup),
      .bus_reset   (bus_reset),
      .host_resume (host_resume),
      .expire      (expire),
      .tok_vld     (tok_vld),
      .tok_rwake   (tok_rwake),
      .susp_wr     (susp_wr),
      .susp_wdata  (susp_wdata),
      .susp_q      (lpm_susp),
      .rwake_en_q  (rwake_en),
      .rwake_req_q (rwake_req)
   );

   assign hs_code = hs_q;

   logic unused_armed;
   assign unused_armed = armed;
endmodule

// File: rtl/usb_lpm_link_ctrl_chk.sv
module usb_lpm_link_ctrl_chk #(
   parameter int HIRD_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tok_vld,
   input logic [HIRD_W-1:0] tok_hird,
   input logic              lpm_sup,
   input logic              data_pend,
   input logic              host_resume,
   input logic              bus_reset,
   input logic [1:0]        hs_code,
   input logic [HIRD_W-1:0] hird_hw,
   input logic              rwake_en,
   input logic              lpm_susp,
   input logic              rwake_req
);
   p_ack_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tok_vld && lpm_sup && !data_pend |=> hs_code == 2'b01);
   p_nyet_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tok_vld && lpm_sup && data_pend |=> hs_code == 2'b10);
   p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tok_vld |=> hs_code == 2'b00);
   p_quiet_unsup_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tok_vld && !lpm_sup |=> hs_code == 2'b00);
   p_hird_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tok_vld |=> hird_hw == $past(tok_hird));
   p_grant_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      host_resume || bus_reset |=> !rwake_en);
   p_resume_wakes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      host_resume && lpm_sup |=> !lpm_susp);
   p_wake_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rwake_req |-> $past(rwake_en) && $past(lpm_susp) && !lpm_susp);
   p_wake_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rwake_req |=> !rwake_req);
   p_hold_unsup_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !lpm_sup && !bus_reset |=> $stable(lpm_susp));
   p_bus_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> !lpm_susp && !rwake_en);
endmodule

bind usb_lpm_link_ctrl usb_lpm_link_ctrl_chk #(.HIRD_W(HIRD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tok_vld     (tok_vld),
   .tok_hird    (tok_hird),
   .lpm_sup     (lpm_sup),
   .data_pend   (data_pend),
   .host_resume (host_resume),
   .bus_reset   (bus_reset),
   .hs_code     (hs_code),
   .hird_hw     (hird_hw),
   .rwake_en    (rwake_en),
   .lpm_susp    (lpm_susp),
   .rwake_req   (rwake_req)
);

// File: tb/usb_lpm_link_ctrl_bench.sv
`timescale 1ns/1ps
module usb_lpm_link_ctrl_bench;
   localparam int HW = 4;
   localparam int WIN = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tok_vld = 0, tok_rwake = 0, host_resume = 0, bus_reset = 0, tick_1ms = 0;
   logic cfg_wr = 0, cfg_sup = 0, cfg_pend = 0, susp_wr = 0, susp_wdata = 0;
   logic [HW-1:0] tok_hird = '0, cfg_hird_sw = '0;
   logic [1:0]    hs_code;
   logic [HW-1:0] hird_hw, hird_sw;
   logic lpm_sup, data_pend, rwake_en, lpm_susp, rwake_req;

   int checks = 0;
   int errors = 0;

   // bench model state
   logic [1:0]    m_code = 0;
   logic [HW-1:0] m_hhw = 0, m_hsw = 0;
   logic m_sup = 0, m_pend = 0, m_rwk = 0, m_susp = 0, m_req = 0, m_arm = 0;
   int   m_cnt = 0;

   always #4 clk = ~clk;

   usb_lpm_link_ctrl #(.HIRD_W(HW), .WINDOW_MS(WIN)) u_usb_lpm_link_ctrl (
      .clk(clk), .rst_n(rst_n), .tok_vld(tok_vld), .tok_hird(tok_hird),
      .tok_rwake(tok_rwake), .host_resume(host_resume), .bus_reset(bus_reset),
      .tick_1ms(tick_1ms), .cfg_wr(cfg_wr), .cfg_sup(cfg_sup), .cfg_pend(cfg_pend),
      .cfg_hird_sw(cfg_hird_sw), .susp_wr(susp_wr), .susp_wdata(susp_wdata),
      .hs_code(hs_code), .hird_hw(hird_hw), .hird_sw(hird_sw), .lpm_sup(lpm_sup),
      .data_pend(data_pend), .rwake_en(rwake_en), .lpm_susp(lpm_susp),
      .rwake_req(rwake_req)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
      end
   endtask

   // expected next state, derived from the requirements
   task automatic model_step();
      logic ack, expire, wake;
      ack    = tok_vld && m_sup && !m_pend;
      wake   = susp_wr && !susp_wdata && m_susp && m_rwk && m_sup;
      expire = 1'b0;
      m_code = tok_vld ? (m_sup ? (m_pend ? 2'b10 : 2'b01) : 2'b00) : 2'b00;
      if (tok_vld) m_hhw = tok_hird;
      if (bus_reset || host_resume) m_arm = 0;
      else if (tok_vld) begin
         m_arm = ack;
         if (ack) m_cnt = WIN;
      end else if (tick_1ms && m_arm) begin
         if (m_cnt == 1) begin m_arm = 0; expire = 1; end
         else m_cnt = m_cnt - 1;
      end
      if (bus_reset) m_susp = 0;
      else if (m_sup) begin
         if (host_resume || wake) m_susp = 0;
         else if (expire)         m_susp = 1;
      end
      if (bus_reset || host_resume || wake) m_rwk = 0;
      else if (tok_vld && m_sup && tok_rwake) m_rwk = 1;
      m_req = wake;
      if (cfg_wr) begin m_sup = cfg_sup; m_pend = cfg_pend; m_hsw = cfg_hird_sw; end
   endtask

   task automatic compare_model();
      check("R1 hs_code model", 32'(hs_code), 32'(m_code));
      check("R4 hird_hw model", 32'(hird_hw), 32'(m_hhw));
      check("R5 rwake_en model", 32'(rwake_en), 32'(m_rwk));
      check("R6 lpm_susp model", 32'(lpm_susp), 32'(m_susp));
      check("R9 rwake_req model", 32'(rwake_req), 32'(m_req));
      check("R12 cfg model", {29'd0, lpm_sup, data_pend, 1'b0} | (32'(hird_sw) << 8),
            {29'd0, m_sup, m_pend, 1'b0} | (32'(m_hsw) << 8));
   endtask

   // one clock: inputs already driven, sample after the edge on the falling edge
   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_model();
      tok_vld = 0; host_resume = 0; bus_reset = 0; tick_1ms = 0;
      cfg_wr = 0; susp_wr = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin tick_1ms = 1; cyc(); cyc(); end
   endtask

   task automatic write_cfg(logic s, logic p, logic [HW-1:0] h);
      cfg_wr = 1; cfg_sup = s; cfg_pend = p; cfg_hird_sw = h; cyc();
   endtask

   task automatic send_tok(logic [HW-1:0] h, logic rw);
      tok_vld = 1; tok_hird = h; tok_rwake = rw; cyc();
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R12 reset state, R3 no handshake at rest
      check("R12 reset outputs", {hs_code, hird_hw, hird_sw, lpm_sup, data_pend,
            rwake_en, lpm_susp, rwake_req}, 0);
      idle(2);
      check("R3 idle no handshake", 32'(hs_code), 0);

      write_cfg(1, 0, 4'd5);
      check("R12 cfg loaded", {lpm_sup, data_pend, hird_sw}, {2'b10, 4'd5});

      send_tok(4'd9, 1);
      check("R1 ACK code", 32'(hs_code), 32'h1);
      check("R4 hird captured", 32'(hird_hw), 32'd9);
      check("R5 grant set", 32'(rwake_en), 1);
      cyc();
      check("R3 ACK lasts one cycle", 32'(hs_code), 0);

      // R6 window length
      ticks(WIN - 1);
      check("R6 not yet asleep", 32'(lpm_susp), 0);
      tick_1ms = 1; cyc();
      check("R6 asleep after window", 32'(lpm_susp), 1);

      // R9 writing 1 has no effect
      susp_wr = 1; susp_wdata = 1; cyc();
      check("R9 write one ignored", {lpm_susp, rwake_req}, 2'b10);
      susp_wr = 1; susp_wdata = 0; cyc();
      check("R9 wake request", {lpm_susp, rwake_req, rwake_en}, 3'b010);
      cyc();
      check("R9 request one cycle", 32'(rwake_req), 0);

      // R7 NYET cancels an open window, R2 NYET code
      send_tok(4'd3, 0);
      ticks(5);
      write_cfg(1, 1, 4'd5);
      send_tok(4'd4, 0);
      check("R2 NYET code", 32'(hs_code), 32'h2);
      ticks(WIN + 2);
      check("R7 NYET closes window", 32'(lpm_susp), 0);

      // R7 a second ACK restarts the count
      write_cfg(1, 0, 4'd5);
      send_tok(4'd1, 0);
      ticks(6);
      send_tok(4'd2, 0);
      ticks(WIN - 1);
      check("R7 restarted window still open", 32'(lpm_susp), 0);
      tick_1ms = 1; cyc();
      check("R7 asleep after restart", 32'(lpm_susp), 1);

      // R9 wake without grant has no effect; R8 host resume
      susp_wr = 1; susp_wdata = 0; cyc();
      check("R9 wake without grant ignored", {lpm_susp, rwake_req}, 2'b10);
      host_resume = 1; cyc();
      check("R8 host resume clears sleep", 32'(lpm_susp), 0);

      // R10 sleep frozen while unsupported, R11 bus reset
      send_tok(4'd6, 1);
      ticks(WIN);
      check("R6 asleep again", 32'(lpm_susp), 1);
      write_cfg(0, 0, 4'd5);
      host_resume = 1; cyc();
      check("R10 held while unsupported", 32'(lpm_susp), 1);
      send_tok(4'd7, 1);
      check("R3 unsupported no handshake", 32'(hs_code), 0);
      bus_reset = 1; cyc();
      check("R11 bus reset clears", {lpm_susp, rwake_en}, 2'b00);

      // constrained random phase checked against the model
      for (int i = 0; i < 4000; i++) begin
         tok_vld     = ($urandom_range(0, 39) == 0);
         tok_hird    = HW'($urandom);
         tok_rwake   = $urandom_range(0, 1);
         host_resume = ($urandom_range(0, 149) == 0);
         bus_reset   = ($urandom_range(0, 399) == 0);
         tick_1ms    = ($urandom_range(0, 2) == 0);
         cfg_wr      = ($urandom_range(0, 59) == 0);
         cfg_sup     = ($urandom_range(0, 3) != 0);
         cfg_pend    = ($urandom_range(0, 2) == 0);
         cfg_hird_sw = HW'($urandom);
         susp_wr     = ($urandom_range(0, 24) == 0);
         susp_wdata  = $urandom_range(0, 1);
         cyc();
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule